// File: doc/BRIEF.md
# Clock Frequency Select Controller with Watchdog Recovery

This block is the control side of a clock generator. It decides which 5-bit frequency code drives the PLL, and whether the PLL runs from a fixed-table setting or from a programmed N/M divider pair. Five strap pins are sampled once, right after reset. A small write-only register port sets the rest: a programmable-mode enable, an override that makes register select bits win over the pins, the select bits, the N and M dividers, and a watchdog enable with a timeout.

In the fixed-table mode, the active code comes from the latched pins or, when the override is set, from the register select bits. In programmable mode, the CPU frequency is GEAR·N/M. The same override-selected code still sets the gear constant and the ratio to the other output groups, so the code output stays meaningful. A new N/M pair is accepted only if its frequency lies within 50 to 248 MHz. Any other pair is dropped, and the previous pair stays in use.

Software arms the watchdog before it attempts a frequency change. If the countdown runs out, the block does three things:
- It returns the clock to the strap setting by clearing the enable and override bits.
- It pulses a system reset for 16 clocks.
- It sets a sticky status flag.

The watchdog FSM has four states:
- CAPTURE: held during reset. Its single clock latches the straps.
- IDLE: no countdown is running.
- ARMED: the countdown is running.
- RECOVER: the reset pulse is being driven.

Its transitions are:
- CAPTURE→IDLE: always, one clock after reset release.
- IDLE→ARMED (arm): a write leaves the enable set and the timeout nonzero.
- ARMED→ARMED (restart): any write that keeps the watchdog enabled with a nonzero timeout.
- ARMED→IDLE (disarm): a write clears the enable or zeroes the timeout.
- ARMED→RECOVER (expire): the last tick arrives with no write in that cycle.
- RECOVER→IDLE: after 16 clocks.

Top module: `clksel_ctrl`

## Requirements
- R1: After reset, the outputs are as follows: programmable flag 0, sys_rst_o 0, sticky flag 0, N=100, M=24, and freq_code_o equal to the strap value latched on the first clock.
- R2: strap_i is sampled only on the first rising clock after rst_n goes high. Later changes on strap_i leave freq_code_o unchanged.
- R3: Register 0 is the control register: bit0 program enable, bit1 override, bit2 watchdog enable, bit7 sticky flag. Register 1 holds the select bits [4:0]. With override 0, freq_code_o equals the latched straps. With override 1, it equals the select bits. Codes 10011 and 01010 pass through unchanged.
- R4: Control bit0 drives prog_mode_o. In programmable mode, freq_code_o still follows the override selection.
- R5: A write to register 2 stages N. A write to register 3 (M) commits the staged N together with that M only if M≠0 and 50·M ≤ 48·N ≤ 248·M. Otherwise div_n_o and div_m_o keep their previous values.
- R6: Register 4 bits [3:0] set the timeout T. With watchdog enable set and T≠0, sys_rst_o rises exactly T·2^TICK_LOG2 clocks after the last register write. T=0 never expires.
- R7: Any register write while the watchdog is armed restarts the full countdown. This holds even for a write that lands in the cycle the countdown would have expired.
- R8: Writing control bit2 as 0 while armed stops the countdown without a reset pulse.
- R9: On expiry, the program enable and override are cleared, so freq_code_o returns to the straps. sys_rst_o is then high for exactly 16 clocks.
- R10: The sticky flag (wdt_expired_o) is set on expiry. Writing 1 to control bit7 clears it. Writing 0 there leaves it set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| strap_i | input | 5 | Frequency strap pins |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register address |
| wr_data_i | input | 8 | Register write data |
| freq_code_o | output | 5 | Active frequency code |
| prog_mode_o | output | 1 | Programmable N/M mode active |
| div_n_o | output | 8 | Committed N divider |
| div_m_o | output | 8 | Committed M divider |
| sys_rst_o | output | 1 | System reset pulse after watchdog expiry |
| wdt_expired_o | output | 1 | Sticky watchdog-expired flag |

## Verification
A register write and watchdog expiry can fall in the same cycle. The bench arms the countdown, counts clocks to the exact expiry edge, and lands a select-bit write on that edge. It judges the result correct only if no reset pulse appears there and the next pulse comes a full timeout after that write. A bounded search over random N/M pairs, together with directed pairs at both frequency limits, checks acceptance against a bench model of the range rule.

// File: rtl/clksel_pkg.sv
package clksel_pkg;
    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] ADDR_CTRL = 3'd0;
    localparam logic [ADDR_W-1:0] ADDR_SEL  = 3'd1;
    localparam logic [ADDR_W-1:0] ADDR_NDIV = 3'd2;
    localparam logic [ADDR_W-1:0] ADDR_MDIV = 3'd3;
    localparam logic [ADDR_W-1:0] ADDR_WDT  = 3'd4;

    localparam int CTRL_PROG   = 0;
    localparam int CTRL_OVR    = 1;
    localparam int CTRL_WDT    = 2;
    localparam int CTRL_STICKY = 7;

    typedef enum logic [1:0] {
        ST_CAPTURE,
        ST_IDLE,
        ST_ARMED,
        ST_RECOVER
    } wd_state_e;
endpackage

// File: rtl/clksel_nm_check.sv
module clksel_nm_check #(
    parameter int DIV_W = 8,
    parameter int GEAR  = 48,
    parameter int FMIN  = 50,
    parameter int FMAX  = 248
) (
    input  logic [DIV_W-1:0] n_i,
    input  logic [DIV_W-1:0] m_i,
    output logic             ok_o
);
    localparam int PROD_W = DIV_W + 9;

    logic [PROD_W-1:0] f_scaled;
    logic [PROD_W-1:0] lim_lo;
    logic [PROD_W-1:0] lim_hi;

    always_comb begin
        f_scaled = PROD_W'(n_i) * PROD_W'(GEAR);
        lim_lo   = PROD_W'(m_i) * PROD_W'(FMIN);
        lim_hi   = PROD_W'(m_i) * PROD_W'(FMAX);
        ok_o     = (m_i != '0) && (f_scaled >= lim_lo) && (f_scaled <= lim_hi);
    end
endmodule

// File: rtl/clksel_regs.sv
module clksel_regs
    import clksel_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int CODE_W = 5,
    parameter int TMO_W  = 4,
    parameter int N_RST  = 100,
    parameter int M_RST  = 24,
    parameter int GEAR   = 48,
    parameter int FMIN   = 50,
    parameter int FMAX   = 248
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [CODE_W-1:0] strap_i,
    input  logic              capture_i,
    input  logic              expire_i,
    input  logic              nm_ok_i,
    output logic              prog_en_o,
    output logic              ovr_o,
    output logic [CODE_W-1:0] sel_o,
    output logic [CODE_W-1:0] strap_q_o,
    output logic [DATA_W-1:0] n_pend_o,
    output logic [DATA_W-1:0] n_o,
    output logic [DATA_W-1:0] m_o,
    output logic              sticky_o,
    output logic              wdt_en_nx_o,
    output logic [TMO_W-1:0]  tmo_nx_o
);
    logic              prog_en_q, ovr_q, wdt_en_q, sticky_q;
    logic [CODE_W-1:0] sel_q, strap_q;
    logic [DATA_W-1:0] n_pend_q, n_q, m_q;
    logic [TMO_W-1:0]  tmo_q;
    logic              ctrl_wr, wdt_wr;

    always_comb begin
        ctrl_wr     = wr_en_i && (addr_i == ADDR_CTRL);
        wdt_wr      = wr_en_i && (addr_i == ADDR_WDT);
        wdt_en_nx_o = ctrl_wr ? wdata_i[CTRL_WDT] : wdt_en_q;
        tmo_nx_o    = wdt_wr ? wdata_i[TMO_W-1:0] : tmo_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prog_en_q <= 1'b0;
            ovr_q     <= 1'b0;
            wdt_en_q  <= 1'b0;
            sticky_q  <= 1'b0;
            sel_q     <= '0;
            strap_q   <= '0;
            n_pend_q  <= DATA_W'(N_RST);
            n_q       <= DATA_W'(N_RST);
            m_q       <= DATA_W'(M_RST);
            tmo_q     <= '0;
        end else begin
            if (capture_i)
                strap_q <= strap_i;
            if (wr_en_i) begin
                case (addr_i)
                    ADDR_CTRL: begin
                        prog_en_q <= wdata_i[CTRL_PROG];
                        ovr_q     <= wdata_i[CTRL_OVR];
                        wdt_en_q  <= wdata_i[CTRL_WDT];
                        if (wdata_i[CTRL_STICKY])
                            sticky_q <= 1'b0;
                    end
                    ADDR_SEL:  sel_q    <= wdata_i[CODE_W-1:0];
                    ADDR_NDIV: n_pend_q <= wdata_i;
                    ADDR_MDIV: begin
                        if (nm_ok_i) begin
                            n_q <= n_pend_q;
                            m_q <= wdata_i;
                        end
                    end
                    ADDR_WDT:  tmo_q    <= wdata_i[TMO_W-1:0];
                    default: ;
                endcase
            end
            if (expire_i) begin
                prog_en_q <= 1'b0;
                ovr_q     <= 1'b0;
                sticky_q  <= 1'b1;
            end
        end
    end

    always_comb begin
        prog_en_o = prog_en_q;
        ovr_o     = ovr_q;
        sel_o     = sel_q;
        strap_q_o = strap_q;
        n_pend_o  = n_pend_q;
        n_o       = n_q;
        m_o       = m_q;
        sticky_o  = sticky_q;
    end

    // R9
    expire_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        expire_i |=> (!prog_en_q && !ovr_q));

    // R10
    sticky_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        expire_i |=> sticky_q);

    // R5
    nm_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (n_q != $past(n_q) || m_q != $past(m_q)) |->
            $past(wr_en_i && addr_i == ADDR_MDIV && nm_ok_i));

    // R5
    nm_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (m_q != '0) && (32'(n_q) * GEAR >= 32'(m_q) * FMIN)
                    && (32'(n_q) * GEAR <= 32'(m_q) * FMAX));

    // R2
    strap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!capture_i && !$past(capture_i)) |-> $stable(strap_q));
endmodule

// File: rtl/clksel_wdt.sv
module clksel_wdt
    import clksel_pkg::*;
#(
    parameter int TMO_W     = 4,
    parameter int TICK_LOG2 = 16,
    parameter int REC_LEN   = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en_i,
    input  logic             wdt_en_nx_i,
    input  logic [TMO_W-1:0] tmo_nx_i,
    output logic             capture_o,
    output logic             expire_o,
    output logic             sys_rst_o
);
    localparam int REC_W = $clog2(REC_LEN);

    wd_state_e              state_q, state_d;
    logic [TMO_W-1:0]       cnt_q;
    logic [TICK_LOG2-1:0]   pre_q;
    logic [REC_W-1:0]       rec_q;
    logic                   tick;
    logic                   keep_armed;

    always_comb begin
        tick       = (pre_q == '1);
        keep_armed = wdt_en_nx_i && (tmo_nx_i != '0);
    end

    // next-state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_CAPTURE: state_d = ST_IDLE;
            ST_IDLE:    if (wr_en_i && keep_armed) state_d = ST_ARMED;
            ST_ARMED: begin
                if (wr_en_i)
                    state_d = keep_armed ? ST_ARMED : ST_IDLE;
                else if (tick && cnt_q == TMO_W'(1))
                    state_d = ST_RECOVER;
            end
            ST_RECOVER: if (rec_q == REC_W'(REC_LEN - 1)) state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_CAPTURE;
        else
            state_q <= state_d;
    end

    // countdown and recovery counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            pre_q <= '0;
            rec_q <= '0;
        end else begin
            if ((state_q == ST_IDLE || state_q == ST_ARMED) && wr_en_i && keep_armed) begin
                cnt_q <= tmo_nx_i;
                pre_q <= '0;
            end else if (state_q == ST_ARMED) begin
                pre_q <= pre_q + 1'b1;
                if (tick)
                    cnt_q <= cnt_q - 1'b1;
            end
            rec_q <= (state_q == ST_RECOVER) ? rec_q + 1'b1 : '0;
        end
    end

    // outputs
    always_comb begin
        capture_o = (state_q == ST_CAPTURE);
        sys_rst_o = (state_q == ST_RECOVER);
        expire_o  = (state_q == ST_ARMED) && (state_d == ST_RECOVER);
    end

    // R9
    rec_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RECOVER && rec_q == REC_W'(REC_LEN - 1)) |=> (state_q == ST_IDLE));

    // R6
    armed_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ARMED) |-> (cnt_q != '0));

    // R7
    restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ARMED && wr_en_i && wdt_en_nx_i && tmo_nx_i != '0)
            |=> (state_q == ST_ARMED && pre_q == '0));

    // R8
    disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ARMED && wr_en_i && !wdt_en_nx_i) |=> (state_q == ST_IDLE));
endmodule

// File: rtl/clksel_ctrl.sv
module clksel_ctrl
    import clksel_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int CODE_W    = 5,
    parameter int TMO_W     = 4,
    parameter int TICK_LOG2 = 16,
    parameter int REC_LEN   = 16,
    parameter int N_RST     = 100,
    parameter int M_RST     = 24,
    parameter int GEAR      = 48,
    parameter int FMIN      = 50,
    parameter int FMAX      = 248
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] strap_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    output logic [CODE_W-1:0] freq_code_o,
    output logic              prog_mode_o,
    output logic [DATA_W-1:0] div_n_o,
    output logic [DATA_W-1:0] div_m_o,
    output logic              sys_rst_o,
    output logic              wdt_expired_o
);
    logic              prog_en, ovr, capture, expire, nm_ok, wdt_en_nx;
    logic [CODE_W-1:0] sel, strap_q;
    logic [DATA_W-1:0] n_pend;
    logic [TMO_W-1:0]  tmo_nx;

    clksel_nm_check #(
        .DIV_W(DATA_W), .GEAR(GEAR), .FMIN(FMIN), .FMAX(FMAX)
    ) u_nm (
        .n_i  (n_pend),
        .m_i  (wr_data_i),
        .ok_o (nm_ok)
    );

    clksel_regs #(
        .DATA_W(DATA_W), .CODE_W(CODE_W), .TMO_W(TMO_W),
        .N_RST(N_RST), .M_RST(M_RST), .GEAR(GEAR), .FMIN(FMIN), .FMAX(FMAX)
    ) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en_i     (wr_en_i),
        .addr_i      (wr_addr_i),
        .wdata_i     (wr_data_i),
        .strap_i     (strap_i),
        .capture_i   (capture),
        .expire_i    (expire),
        .nm_ok_i     (nm_ok),
        .prog_en_o   (prog_en),
        .ovr_o       (ovr),
        .sel_o       (sel),
        .strap_q_o   (strap_q),
        .n_pend_o    (n_pend),
        .n_o         (div_n_o),
        .m_o         (div_m_o),
        .sticky_o    (wdt_expired_o),
        .wdt_en_nx_o (wdt_en_nx),
        .tmo_nx_o    (tmo_nx)
    );

    clksel_wdt #(
        .TMO_W(TMO_W), .TICK_LOG2(TICK_LOG2), .REC_LEN(REC_LEN)
    ) u_wdt (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en_i     (wr_en_i),
        .wdt_en_nx_i (wdt_en_nx),
        .tmo_nx_i    (tmo_nx),
        .capture_o   (capture),
        .expire_o    (expire),
        .sys_rst_o   (sys_rst_o)
    );

    always_comb begin
        freq_code_o = ovr ? sel : strap_q;
        prog_mode_o = prog_en;
    end

    // R3
    code_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!capture && !ovr) |-> (freq_code_o == strap_q));
endmodule

// File: tb/clksel_ctrl_tb_top.sv
module clksel_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int TICK_LOG2  = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] strap = 5'b10011;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [4:0] freq_code;
    logic       prog_mode;
    logic [7:0] div_n, div_m;
    logic       sys_rst, wdt_expired;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    clksel_ctrl #(.TICK_LOG2(TICK_LOG2)) dut_i (
        .clk(clk), .rst_n(rst_n), .strap_i(strap),
        .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
        .freq_code_o(freq_code), .prog_mode_o(prog_mode),
        .div_n_o(div_n), .div_m_o(div_m),
        .sys_rst_o(sys_rst), .wdt_expired_o(wdt_expired)
    );

    function automatic bit nm_ok(int n, int m);
        return (m != 0) && (48*n >= 50*m) && (48*n <= 248*m);
    endfunction

    task automatic chk(string req, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(logic [2:0] a, logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic count_to_rst(output int c);
        c = 0;
        do begin
            @(posedge clk); c++;
            @(negedge clk);
        end while (!sys_rst && c < 1000);
    endtask

    task automatic quiet(int cycles, string req);
        int seen = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (sys_rst) seen = 1;
        end
        chk(req, seen, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        int c, w;
        int mn, mm, en, em;
        logic [4:0] esel;
        bit eovr;
        int unsigned seed;
        seed = $urandom(32'h5EED_0042);

        // R1, R2: strap capture on first clock
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
        strap = 5'b01010;
        chk("R1 code", freq_code, 5'b10011);
        chk("R1 prog", prog_mode, 0);
        chk("R1 n", div_n, 100);
        chk("R1 m", div_m, 24);
        chk("R1 rst", sys_rst, 0);
        chk("R1 sticky", wdt_expired, 0);
        repeat (5) @(negedge clk);
        strap = 5'b00111;
        @(negedge clk);
        chk("R2 strap ignored", freq_code, 5'b10011);

        // R3 directed
        wr(3'd1, 8'b0000_1010);
        chk("R3 ovr0 keeps strap", freq_code, 5'b10011);
        wr(3'd0, 8'h02);
        chk("R3 ovr1 sel", freq_code, 5'b01010);
        // R3 random
        esel = 5'b01010; eovr = 1;
        for (int i = 0; i < 20; i++) begin
            if ($urandom % 2) begin
                esel = 5'($urandom);
                wr(3'd1, {3'b000, esel});
            end else begin
                eovr = 1'($urandom);
                wr(3'd0, {6'd0, eovr, 1'b0});
            end
            chk("R3 random code", freq_code, eovr ? esel : 5'b10011);
        end

        // R4
        wr(3'd1, 8'b0001_0011);
        wr(3'd0, 8'h03);
        chk("R4 prog flag", prog_mode, 1);
        chk("R4 code follows sel", freq_code, 5'b10011);
        wr(3'd1, 8'b0000_1010);
        chk("R4 code follows sel2", freq_code, 5'b01010);
        wr(3'd0, 8'h01);
        chk("R4 code follows strap", freq_code, 5'b10011);

        // R5 directed boundaries
        en = 100; em = 24;
        mn = 100; mm = 20;   // 240 MHz accepted
        wr(3'd2, 8'(mn)); wr(3'd3, 8'(mm)); en = mn; em = mm;
        chk("R5 accept n", div_n, en); chk("R5 accept m", div_m, em);
        wr(3'd2, 8'd200); wr(3'd3, 8'd20);      // 480 rejected
        chk("R5 reject high", div_n, en);
        wr(3'd2, 8'd125); wr(3'd3, 8'd24);      // just above 248
        chk("R5 reject edge", div_n, en);
        wr(3'd2, 8'd124); wr(3'd3, 8'd24);      // exactly 248
        en = 124; em = 24;
        chk("R5 upper edge n", div_n, en); chk("R5 upper edge m", div_m, em);
        wr(3'd2, 8'd25); wr(3'd3, 8'd24);       // exactly 50
        en = 25; em = 24;
        chk("R5 lower edge n", div_n, en);
        wr(3'd2, 8'd50); wr(3'd3, 8'd50);       // 48 rejected
        chk("R5 reject low", div_m, em);
        wr(3'd2, 8'd0); wr(3'd3, 8'd0);         // M=0 rejected
        chk("R5 reject m0", div_m, em);
        for (int i = 0; i < 30; i++) begin
            mn = 1 + ($urandom % 255);
            mm = $urandom % 256;
            wr(3'd2, 8'(mn)); wr(3'd3, 8'(mm));
            if (nm_ok(mn, mm)) begin en = mn; em = mm; end
            chk("R5 random n", div_n, en);
            chk("R5 random m", div_m, em);
        end

        // R6, R9, R10: expiry with timeout 3
        wr(3'd0, 8'h03);
        wr(3'd4, 8'd3);
        wr(3'd0, 8'h07);
        count_to_rst(c);
        chk("R6 expiry cycles", c, 3 << TICK_LOG2);
        chk("R9 prog cleared", prog_mode, 0);
        chk("R9 code back to strap", freq_code, 5'b10011);
        chk("R10 sticky set", wdt_expired, 1);
        w = 0;
        while (sys_rst && w < 100) begin @(negedge clk); w++; end
        chk("R9 pulse width", w, 16);

        // R10 W1C
        wr(3'd0, 8'h00);
        chk("R10 write 0 keeps", wdt_expired, 1);
        wr(3'd0, 8'h80);
        chk("R10 write 1 clears", wdt_expired, 0);

        // R6 timeout 0 never expires
        wr(3'd4, 8'd0);
        wr(3'd0, 8'h04);
        quiet(300, "R6 tmo0 no reset");
        wr(3'd0, 8'h00);

        // R7 restart by a write mid-count
        wr(3'd4, 8'd2);
        wr(3'd0, 8'h04);
        repeat (20) @(negedge clk);
        wr(3'd1, 8'h05);
        count_to_rst(c);
        chk("R7 restart mid-count", c, 2 << TICK_LOG2);
        repeat (20) @(negedge clk);

        // R7 write exactly on the expiry edge
        wr(3'd0, 8'h00);
        wr(3'd0, 8'h04);
        repeat ((2 << TICK_LOG2) - 1) @(posedge clk);
        wr(3'd1, 8'h06);
        count_to_rst(c);
        chk("R7 same-cycle restart", c, 2 << TICK_LOG2);
        repeat (20) @(negedge clk);

        // R8 disarm
        wr(3'd0, 8'h80);
        wr(3'd4, 8'd1);
        wr(3'd0, 8'h04);
        repeat (10) @(negedge clk);
        wr(3'd0, 8'h00);
        quiet(100, "R8 disarm no reset");
        chk("R8 sticky untouched", wdt_expired, 0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule